// File: doc/BRIEF.md
# Sixteen-bit free-running timer with two compare outputs

This block is a 16-bit up-counter that never stops on its own, paired with two independent compare channels. A small prescaler or an external clock input produces the count pulse, and a 2-bit field picks which one is used. On every count the counter value is checked against both compare registers. A hit sets that channel's status flag. If the channel is enabled, the hit also drives a programmed level onto its output pin. When the counter wraps from all ones to zero, an overflow flag is raised.

Software reaches the block through an 8-bit register bus. A single byte-wide holding latch is shared by all 16-bit transfers. Writing a high byte parks it in the latch. The matching low-byte write then commits the full word in one cycle. Reading the counter's high byte snapshots its low byte into the latch, so the following low-byte read is coherent with it. The two compare registers sit behind one pair of addresses, and a select bit in the output-control register steers accesses to one or the other. A standby input returns the counter and both compare registers to their idle values without a full reset.

Top module: `frt16_dual_compare`

## Requirements
- R1: After reset the counter reads 0x0000, both compare registers read 0xFFFF, all status bits read 0 and both output pins are 0.
- R2: Writing address 3 (counter high) loads the shared latch. A later write to address 4 (counter low) sets the counter to {latch, data} in one cycle. Otherwise the counter adds one on each count pulse.
- R3: Reading address 3 returns the counter's high byte and copies its low byte into the shared latch. Reading address 4 returns the latch contents, not the live low byte.
- R4: Control register address 0, bits [1:0]: 0, 1 and 2 make the count pulse the system clock divided by 2, 8 and 32 respectively.
- R5: Clock-select value 3 counts rising edges of the external clock input after a two-stage synchroniser, one count per edge.
- R6: A count from 0xFFFF to 0x0000 sets status bit 0 (status register at address 1).
- R7: When the counter takes a value, through a count or a write, that equals a compare register, the status bit of that channel is set: bit 1 for channel A and bit 2 for channel B.
- R8: Output-control register (address 2): bit 1 enables pin A and bit 2 enables pin B; bit 3 is the level for A and bit 4 the level for B. On a match, an enabled pin takes its level. A pin holds its value at all other times.
- R9: Output-control bit 0 selects the compare register that addresses 5 (high) and 6 (low) reach: 0 selects A and 1 selects B. Compare writes use the shared latch in the same way as counter writes.
- R10: A status bit clears only when a 0 is written to it after a read of the status register that saw it set. Writing 1, or writing 0 without such a prior read, leaves it set.
- R11: While standby is high, the counter is held at 0x0000 and both compare registers at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Standby request; clears counter, presets compares |
| ext_clk_i | input | 1 | External count clock (asynchronous) |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid during the read strobe |
| cmp_out_a_o | output | 1 | Channel A output pin |
| cmp_out_b_o | output | 1 | Channel B output pin |

## Verification
The bench uses the default parameters: a 16-bit counter over an 8-bit bus, with prescaler taps at 2, 8 and 32. For exact checks it selects the external clock and holds it still. Each count then happens only when the bench issues an edge. This makes the wrap from 0xFFFF, a latched low byte read after the counter has moved on, and single-step compare hits reachable in a few cycles. The divider settings are measured by counting over a fixed window.

// File: rtl/frt16_pkg.sv
// Package: register addresses and status bit positions shared by the
// timer and its checker. Assumes a 3-bit register address.
package frt16_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_STAT  = 3'd1,
        REG_OCTL  = 3'd2,
        REG_CNTH  = 3'd3,
        REG_CNTL  = 3'd4,
        REG_CMPH  = 3'd5,
        REG_CMPL  = 3'd6
    } reg_addr_e;

    localparam int ST_OVF   = 0;
    localparam int ST_HIT_A = 1;
    localparam int ST_HIT_B = 2;
    localparam int ST_W     = 3;
endpackage

// File: rtl/frt16_prescale.sv
// Count-pulse generator. A free-running divider provides three tap
// rates; the fourth selection is an external clock that is synchronised
// through two flops and edge-detected. Assumes SH0 < SH1 < SH2.
module frt16_prescale #(
    parameter int SH0 = 1,
    parameter int SH1 = 3,
    parameter int SH2 = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby_i,
    input  logic [1:0] sel_i,
    input  logic       ext_i,
    output logic       tick_o
);
    localparam int PW = SH2;

    logic [PW-1:0] div_q;
    logic [2:0]    sync_q;

    // Free-running divider, parked at zero during standby.
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_i};
    end

    // Select the pulse source.
    always_comb begin
        case (sel_i)
            2'd0:    tick_o = &div_q[SH0-1:0];
            2'd1:    tick_o = &div_q[SH1-1:0];
            2'd2:    tick_o = &div_q[SH2-1:0];
            default: tick_o = sync_q[1] & ~sync_q[2];
        endcase
    end
endmodule

// File: rtl/frt16_cmp_chan.sv
// One compare channel: holds the compare word, flags a hit when a freshly
// updated counter equals it, and drives the channel pin on an enabled hit.
// Assumes fresh_i is high for one cycle after each counter update.
module frt16_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             fresh_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             oe_i,
    input  logic             lvl_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             hit_o,
    output logic             pin_o
);
    // Compare word: preset to all ones by reset and standby.
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) cmp_o <= '1;
        else if (load_i)         cmp_o <= load_val_i;
    end

    // Hit only on the first cycle the counter shows a new value.
    assign hit_o = fresh_i && (cnt_i == cmp_o);

    // Output pin: takes the programmed level on an enabled hit.
    always_ff @(posedge clk) begin
        if (!rst_n)             pin_o <= 1'b0;
        else if (hit_o && oe_i) pin_o <= lvl_i;
    end
endmodule

// File: rtl/frt16_dual_compare.sv
// Top of the timer: counter, status flags, byte bus with a shared holding
// latch, and two compare channels. Assumes single-cycle bus strobes and
// that CNT_W is twice BYTE_W.
module frt16_dual_compare
    import frt16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int SH0    = 1,
    parameter int SH1    = 3,
    parameter int SH2    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              ext_clk_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              cmp_out_a_o,
    output logic              cmp_out_b_o
);
    localparam int NCH = 2;

    logic [1:0]                  cs_q;
    logic [4:0]                  octl_q;
    logic [ST_W-1:0]             flags_q, armed_q, flag_set;
    logic [BYTE_W-1:0]           temp_q;
    logic [CNT_W-1:0]            cnt_q;
    logic                        fresh_q;
    logic                        tick_raw, tick_s, cnt_load;
    logic [NCH-1:0]              hit, pins, cmp_load;
    logic [NCH-1:0][CNT_W-1:0]   cmp_q;
    logic                        wr_ctrl, wr_stat, wr_octl, wr_cnth, wr_cmph;
    logic                        rd_stat, rd_cnth;
    logic [CNT_W-1:0]            cmp_sel;

    // Decode bus strobes.
    assign wr_ctrl  = bus_wr_i && (bus_addr_i == REG_CTRL);
    assign wr_stat  = bus_wr_i && (bus_addr_i == REG_STAT);
    assign wr_octl  = bus_wr_i && (bus_addr_i == REG_OCTL);
    assign wr_cnth  = bus_wr_i && (bus_addr_i == REG_CNTH);
    assign wr_cmph  = bus_wr_i && (bus_addr_i == REG_CMPH);
    assign cnt_load = bus_wr_i && (bus_addr_i == REG_CNTL) && !standby_i;
    assign rd_stat  = bus_rd_i && (bus_addr_i == REG_STAT);
    assign rd_cnth  = bus_rd_i && (bus_addr_i == REG_CNTH);

    frt16_prescale #(.SH0(SH0), .SH1(SH1), .SH2(SH2)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .sel_i     (cs_q),
        .ext_i     (ext_clk_i),
        .tick_o    (tick_raw)
    );
    assign tick_s = tick_raw && !standby_i;

    // Control and output-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= '0;
            octl_q <= '0;
        end else begin
            if (wr_ctrl) cs_q   <= bus_wdata_i[1:0];
            if (wr_octl) octl_q <= bus_wdata_i[4:0];
        end
    end

    // Shared holding latch: high-byte writes, or counter snapshot on high read.
    always_ff @(posedge clk) begin
        if (!rst_n)                temp_q <= '0;
        else if (wr_cnth || wr_cmph) temp_q <= bus_wdata_i;
        else if (rd_cnth)          temp_q <= cnt_q[BYTE_W-1:0];
    end

    // Counter: bus commit wins over counting; standby clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) cnt_q <= '0;
        else if (cnt_load)       cnt_q <= {temp_q, bus_wdata_i};
        else if (tick_s)         cnt_q <= cnt_q + 1'b1;
    end

    // Marks the cycle after the counter took a new value.
    always_ff @(posedge clk) begin
        if (!rst_n) fresh_q <= 1'b0;
        else        fresh_q <= (tick_s || cnt_load) && !standby_i;
    end

    // Compare channels, steered by the select bit for bus writes.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cmp_load[g] = bus_wr_i && (bus_addr_i == REG_CMPL)
                             && (octl_q[0] == g[0]) && !standby_i;
        frt16_cmp_chan #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .standby_i  (standby_i),
            .cnt_i      (cnt_q),
            .fresh_i    (fresh_q),
            .load_i     (cmp_load[g]),
            .load_val_i ({temp_q, bus_wdata_i}),
            .oe_i       (octl_q[1+g]),
            .lvl_i      (octl_q[3+g]),
            .cmp_o      (cmp_q[g]),
            .hit_o      (hit[g]),
            .pin_o      (pins[g])
        );
    end
    assign cmp_out_a_o = pins[0];
    assign cmp_out_b_o = pins[1];

    // Hardware set sources for the status bits.
    always_comb begin
        flag_set           = '0;
        flag_set[ST_OVF]   = tick_s && !cnt_load && (cnt_q == '1);
        flag_set[ST_HIT_A] = hit[0];
        flag_set[ST_HIT_B] = hit[1];
    end

    // Status flags with read-then-write-zero clearing; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            armed_q <= '0;
        end else begin
            if (wr_stat) begin
                flags_q <= (flags_q & ~(armed_q & ~bus_wdata_i[ST_W-1:0])) | flag_set;
                armed_q <= '0;
            end else begin
                flags_q <= flags_q | flag_set;
                if (rd_stat) armed_q <= armed_q | flags_q;
            end
        end
    end

    // Read data mux.
    assign cmp_sel = octl_q[0] ? cmp_q[1] : cmp_q[0];
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            REG_CTRL: bus_rdata_o[1:0]      = cs_q;
            REG_STAT: bus_rdata_o[ST_W-1:0] = flags_q;
            REG_OCTL: bus_rdata_o[4:0]      = octl_q;
            REG_CNTH: bus_rdata_o = cnt_q[CNT_W-1:BYTE_W];
            REG_CNTL: bus_rdata_o = temp_q;
            REG_CMPH: bus_rdata_o = cmp_sel[CNT_W-1:BYTE_W];
            REG_CMPL: bus_rdata_o = cmp_sel[BYTE_W-1:0];
            default:  bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/frt16_dual_compare_chk.sv
// Checker for the timer: relates count pulses, bus strobes, flags and pins
// across cycles. Attached to every instance of the top by bind.
module frt16_dual_compare_chk
    import frt16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      standby_i,
    input logic [ADDR_W-1:0]         bus_addr_i,
    input logic                      bus_wr_i,
    input logic [BYTE_W-1:0]         bus_wdata_i,
    input logic [CNT_W-1:0]          cnt_q,
    input logic                      tick_s,
    input logic                      cnt_load,
    input logic [ST_W-1:0]           flags_q,
    input logic [1:0]                hit,
    input logic                      cmp_out_a_o,
    input logic [1:0][CNT_W-1:0]     cmp_q
);
    // R2: a count pulse without a bus commit advances by exactly one.
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_s && !cnt_load && !standby_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6: counting out of all ones raises the overflow bit.
    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_s && !cnt_load && !standby_i && (cnt_q == '1)) |=> flags_q[ST_OVF]);

    // R7: a channel A hit is visible in its status bit next cycle.
    assert_hit_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> flags_q[ST_HIT_A]);

    // R8: pin A never moves without a channel A hit.
    assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[0] |=> $stable(cmp_out_a_o));

    // R10: writing 1 to a set bit keeps it set.
    assert_flag_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && (bus_addr_i == REG_STAT) && bus_wdata_i[ST_OVF] && flags_q[ST_OVF])
        |=> flags_q[ST_OVF]);

    // R11: standby leaves the counter at zero and compares at all ones.
    assert_standby_R11: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> ((cnt_q == '0) && (cmp_q[0] == '1) && (cmp_q[1] == '1)));
endmodule

bind frt16_dual_compare frt16_dual_compare_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .cnt_q       (cnt_q),
    .tick_s      (tick_s),
    .cnt_load    (cnt_load),
    .flags_q     (flags_q),
    .hit         (hit),
    .cmp_out_a_o (cmp_out_a_o),
    .cmp_q       (cmp_q)
);

// File: tb/frt16_dual_compare_tb.sv
// Directed bench for the dual-compare timer: one task per scenario.
module frt16_dual_compare_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       ext_clk = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       out_a, out_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frt16_dual_compare dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby),
        .ext_clk_i   (ext_clk),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .cmp_out_a_o (out_a),
        .cmp_out_b_o (out_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp, input int tol);
        checks++;
        if (act < exp - tol || act > exp + tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d+-%0d", req, act, exp, tol);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd = 1'b0;
    endtask

    task automatic write_cnt(input logic [15:0] v);
        bus_write(3'd3, v[15:8]);
        bus_write(3'd4, v[7:0]);
    endtask

    task automatic write_cmp(input logic [15:0] v);
        bus_write(3'd5, v[15:8]);
        bus_write(3'd6, v[7:0]);
    endtask

    task automatic read_cnt(output logic [15:0] v);
        logic [7:0] h, l;
        bus_read(3'd3, h);
        bus_read(3'd4, l);
        v = {h, l};
    endtask

    task automatic read_cmp(output logic [15:0] v);
        logic [7:0] h, l;
        bus_read(3'd5, h);
        bus_read(3'd6, l);
        v = {h, l};
    endtask

    task automatic ext_edge();
        @(negedge clk) ext_clk = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) ext_clk = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    // R1: reset values at the ports.
    task automatic t_reset();
        logic [15:0] v;
        logic [7:0]  s;
        check("R1 pin A", out_a, 0);
        check("R1 pin B", out_b, 0);
        read_cnt(v);
        check("R1 counter", v, 16'h0000);
        read_cmp(v);
        check("R1 compare A", v, 16'hFFFF);
        bus_write(3'd2, 8'h01);
        read_cmp(v);
        check("R1 compare B", v, 16'hFFFF);
        bus_write(3'd2, 8'h00);
        bus_read(3'd1, s);
        check("R1 status", s, 8'h00);
    endtask

    // R2, R3, R5: commit, coherent snapshot, external single steps.
    task automatic t_coherent();
        logic [15:0] v;
        logic [7:0]  b;
        bus_write(3'd0, 8'h03);
        write_cnt(16'h1234);
        read_cnt(v);
        check("R2 commit", v, 16'h1234);
        write_cnt(16'h12FF);
        bus_read(3'd3, b);
        check("R3 high read", b, 8'h12);
        ext_edge();
        bus_read(3'd4, b);
        check("R3 latched low", b, 8'hFF);
        read_cnt(v);
        check("R5 one count per ext edge", v, 16'h1300);
        ext_edge();
        ext_edge();
        read_cnt(v);
        check("R5 two edges", v, 16'h1302);
    endtask

    // R6, R10: wrap flag and its clearing protocol.
    task automatic t_overflow();
        logic [15:0] v;
        logic [7:0]  s;
        write_cnt(16'hFFFF);
        ext_edge();
        read_cnt(v);
        check("R6 wrap to zero", v, 16'h0000);
        bus_write(3'd1, 8'h00);
        bus_read(3'd1, s);
        check("R10 zero without read keeps bit", s[0], 1);
        bus_write(3'd1, 8'h01);
        bus_read(3'd1, s);
        check("R10 one write keeps bit / R6 set", s[0], 1);
        bus_write(3'd1, 8'h00);
        bus_read(3'd1, s);
        check("R10 cleared after read", s, 8'h00);
    endtask

    // R7, R8, R9: compare hits, pins, shared address.
    task automatic t_compare();
        logic [15:0] v;
        logic [7:0]  s;
        bus_write(3'd2, 8'h0A);
        write_cmp(16'h0005);
        write_cnt(16'h0004);
        ext_edge();
        check("R8 pin A to level 1", out_a, 1);
        check("R8 pin B untouched", out_b, 0);
        bus_read(3'd1, s);
        check("R7 flag A", s[2:1], 2'b01);
        bus_write(3'd2, 8'h0B);
        write_cmp(16'h0007);
        read_cmp(v);
        check("R9 select B", v, 16'h0007);
        bus_write(3'd2, 8'h0A);
        read_cmp(v);
        check("R9 select A unchanged", v, 16'h0005);
        ext_edge();
        ext_edge();
        bus_read(3'd1, s);
        check("R7 flag B", s[2], 1);
        check("R8 pin B disabled", out_b, 0);
        check("R8 pin A holds", out_a, 1);
        bus_write(3'd2, 8'h02);
        write_cnt(16'h0004);
        ext_edge();
        check("R8 pin A to level 0", out_a, 0);
    endtask

    // R4: divider rates measured over a 160-cycle window.
    task automatic t_rate(input logic [1:0] sel, input int exp);
        logic [15:0] v;
        bus_write(3'd0, 8'h03);
        write_cnt(16'h0000);
        bus_write(3'd0, {6'd0, sel});
        repeat (159) @(posedge clk);
        bus_write(3'd0, 8'h03);
        read_cnt(v);
        check_near("R4 divider rate", v, exp, 1);
    endtask

    // R11: standby clears counter and presets compares.
    task automatic t_standby();
        logic [15:0] v;
        bus_write(3'd0, 8'h03);
        write_cnt(16'h4321);
        bus_write(3'd2, 8'h00);
        write_cmp(16'h0102);
        @(negedge clk) standby = 1'b1;
        @(negedge clk) standby = 1'b0;
        read_cnt(v);
        check("R11 counter cleared", v, 16'h0000);
        read_cmp(v);
        check("R11 compare A preset", v, 16'hFFFF);
        bus_write(3'd2, 8'h01);
        read_cmp(v);
        check("R11 compare B preset", v, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_coherent();
        t_overflow();
        t_compare();
        t_rate(2'd0, 80);
        t_rate(2'd1, 20);
        t_rate(2'd2, 5);
        t_standby();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule